// File: doc/BRIEF.md
# Run-Mode Clock Source Switch Controller

This block picks the clock that drives the core and the peripherals. There are three families of source. The first is a primary oscillator, which can optionally be taken through a PLL. The second is a secondary low-frequency oscillator. The third is an internal oscillator block whose frequency is set by a 3-bit field. A 2-bit select field names the wanted source. The sequencing runs in the domain of the fastest internal clock, which never stops. It first synchronises the field. It then drives the primary-oscillator and PLL enables, and it moves a one-hot grant into a glitch-free clock multiplexer.

The primary source is never used straight away. While it is not selected it is switched off. On return it must first finish a start-up count of primary periods. When the PLL path is configured, a lock interval follows that count. During the whole wait the core keeps running on the previous clock. A status flag rises only once the primary path has become the active clock. A change of the internal frequency field acts at once, with no switch sequence.

Top module: `run_clk_switch`

## Requirements
- R1: The select field `src_sel_i` is decoded as follows: 00 chooses the primary path, 01 chooses the secondary oscillator, and 1x chooses the internal block. Bit 0 is ignored whenever bit 1 is set. Once a switch has settled, both output clocks run at the period of the chosen source.
- R2: Once a switch away from the primary path has settled, `prim_en_o` and `pll_en_o` are 0. While the select field has shown the internal block for three control cycles, `osc_ready_o` is 0.
- R3: On a return to the primary path, the primary clock is not used until `OST_CYCLES` primary periods have been counted after `prim_en_o` rises. `osc_ready_o` stays 0 until that point.
- R4: When `pll_use_i` is 1, `pll_en_o` follows `prim_en_o`. A further `LOCK_CYCLES` primary periods are counted after the start-up count, and the primary path then delivers `pll_clk_i`. `pll_en_o` is never 1 while `prim_en_o` is 0.
- R5: `osc_ready_o` is 1 only while the primary path is the active output clock and `prim_en_o` is 1.
- R6: During a start-up or lock wait, the output clock keeps the period of the clock that was active before.
- R7: A handover produces no output pulse, high or low, shorter than half a period of the faster of the two sources involved. At most one source enable of the multiplexer is ever active.
- R8: The field `int_freq_i` sets the internal clock. Code 111 gives the fast internal clock divided by 1. Each lower code down to 001 doubles the division ratio, so 001 gives a division by 64. Code 000 gives `int_slow_clk_i`. A change of the field takes effect within a few periods of the new clock, and it starts no switch sequence.
- R9: `cpu_clk_o` and `periph_clk_o` are the same clock at every moment.
- R10: After reset, `osc_ready_o` is 0 and `prim_en_o` is 1. The core runs on the internal path until the first start-up completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_fast_clk_i | input | 1 | Fastest internal clock; also the control clock |
| int_slow_clk_i | input | 1 | Low-frequency internal clock |
| prim_clk_i | input | 1 | Primary oscillator clock |
| pll_clk_i | input | 1 | PLL output clock |
| sec_clk_i | input | 1 | Secondary oscillator clock |
| src_sel_i | input | 2 | Source select field |
| int_freq_i | input | IFREQ_W | Internal frequency code |
| pll_use_i | input | 1 | Route the primary path through the PLL (change only while the primary path is off) |
| cpu_clk_o | output | 1 | Core clock |
| periph_clk_o | output | 1 | Peripheral clock |
| prim_en_o | output | 1 | Primary oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| osc_ready_o | output | 1 | Primary start-up complete and in use |

## Verification
The bench keeps `OST_CYCLES` at its default of 1024. This means the exact start-up boundary is checked, shortly before and shortly after the point where the primary clock takes over. `LOCK_CYCLES` is cut to 200. With that value, a full start-up plus lock on the PLL path takes about 12 microseconds, so the bench can afford several such sequences. Among them is a bounce away from the primary path and straight back, which must restart the whole count. The sources run at clearly different periods: 6 ns, 8 ns, 10 ns, 30 ns and 200 ns. Every internal division, and the identity of every source, can therefore be told apart from a single period measurement.

// File: rtl/rcs_pkg.sv
`timescale 1ns/1ps
package rcs_pkg;
  localparam int unsigned NSRC = 3;

  typedef enum logic [1:0] {
    SRC_PRI = 2'd0,
    SRC_SEC = 2'd1,
    SRC_INT = 2'd2
  } src_e;

  function automatic src_e decode_sel(input logic [1:0] sel);
    if (sel[1])      return SRC_INT;
    else if (sel[0]) return SRC_SEC;
    else             return SRC_PRI;
  endfunction
endpackage

// File: rtl/rcs_sync.sv
`timescale 1ns/1ps
module rcs_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/rcs_ost_timer.sv
`timescale 1ns/1ps
module rcs_ost_timer #(
  parameter int unsigned OST_CYCLES  = 1024,
  parameter int unsigned LOCK_CYCLES = 8000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pll_i,
  output logic done_o
);
  localparam int unsigned MAXC = OST_CYCLES + LOCK_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [1:0]    cfg_s;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  rcs_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pll_i, en_i}),
    .q_o   (cfg_s)
  );

  // start-up count, plus lock interval when the PLL path is used
  assign limit = cfg_s[1] ? CW'(MAXC) : CW'(OST_CYCLES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (!cfg_s[0]) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (!done_o) begin
      if (cnt_q == limit - 1'b1) done_o <= 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rcs_int_div.sv
`timescale 1ns/1ps
module rcs_int_div #(
  parameter int unsigned FW = 3
) (
  input  logic          fast_clk_i,
  input  logic          slow_clk_i,
  input  logic          rst_ni,
  input  logic [FW-1:0] code_i,
  output logic          clk_o
);
  localparam int unsigned NCODE = 2 ** FW;
  localparam int unsigned NDIV  = NCODE - 2;

  logic [NDIV-1:0]  cnt_q;
  logic [NCODE-1:0] tap;

  always_ff @(posedge fast_clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign tap[0]       = slow_clk_i;
  assign tap[NCODE-1] = fast_clk_i;

  // code c divides by 2^(NCODE-1-c)
  for (genvar c = 1; c < NCODE - 1; c++) begin : g_tap
    assign tap[c] = cnt_q[NCODE-2-c];
  end

  // deliberately unsequenced: a code change acts at once
  assign clk_o = tap[code_i];
endmodule

// File: rtl/rcs_glitch_free_mux.sv
`timescale 1ns/1ps
module rcs_glitch_free_mux #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] en_o,
  output logic         clk_o
);
  logic [N-1:0] arm;
  logic [N-1:0] busy;
  logic [N-1:0] gated;

  assign busy = arm | en_o;

  for (genvar k = 0; k < N; k++) begin : g_leg
    logic others;
    logic arm_q;
    logic en_q;

    assign others = |(busy & ~(N'(1) << k));

    always_ff @(posedge clk_i[k] or negedge rst_ni) begin
      if (!rst_ni) arm_q <= 1'b0;
      else         arm_q <= req_i[k] & ~others;
    end

    // enable moves only while its clock is low
    always_ff @(negedge clk_i[k] or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else         en_q <= arm_q;
    end

    assign arm[k]   = arm_q;
    assign en_o[k]  = en_q;
    assign gated[k] = clk_i[k] & en_q;
  end

  assign clk_o = |gated;
endmodule

// File: rtl/run_clk_switch.sv
`timescale 1ns/1ps
module run_clk_switch
  import rcs_pkg::*;
#(
  parameter int unsigned OST_CYCLES  = 1024,
  parameter int unsigned LOCK_CYCLES = 8000,
  parameter int unsigned IFREQ_W     = 3
) (
  input  logic               rst_ni,
  input  logic               int_fast_clk_i,
  input  logic               int_slow_clk_i,
  input  logic               prim_clk_i,
  input  logic               pll_clk_i,
  input  logic               sec_clk_i,
  input  logic [1:0]         src_sel_i,
  input  logic [IFREQ_W-1:0] int_freq_i,
  input  logic               pll_use_i,
  output logic               cpu_clk_o,
  output logic               periph_clk_o,
  output logic               prim_en_o,
  output logic               pll_en_o,
  output logic               osc_ready_o
);
  localparam int unsigned SW = 2 + NSRC + 1;

  logic            int_clk;
  logic            prim_path_clk;
  logic            tmr_done;
  logic [NSRC-1:0] mux_en;
  logic [NSRC-1:0] mux_req;
  logic [NSRC-1:0] src_clk;
  logic            out_clk;

  logic [SW-1:0]   ctl_s;
  logic [1:0]      sel_s;
  logic [NSRC-1:0] en_s;
  logic            done_s;

  src_e grant_q;
  src_e target;
  logic off_wait_q;
  logic to_pri;
  logic prim_req;
  logic prim_act;
  logic prim_ok;

  rcs_int_div #(.FW(IFREQ_W)) u_int_div (
    .fast_clk_i(int_fast_clk_i),
    .slow_clk_i(int_slow_clk_i),
    .rst_ni    (rst_ni),
    .code_i    (int_freq_i),
    .clk_o     (int_clk)
  );

  assign prim_path_clk = pll_use_i ? pll_clk_i : prim_clk_i;

  rcs_ost_timer #(
    .OST_CYCLES (OST_CYCLES),
    .LOCK_CYCLES(LOCK_CYCLES)
  ) u_ost (
    .clk_i (prim_clk_i),
    .rst_ni(rst_ni),
    .en_i  (prim_en_o),
    .pll_i (pll_use_i),
    .done_o(tmr_done)
  );

  rcs_sync #(.W(SW)) u_ctl_sync (
    .clk_i (int_fast_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({tmr_done, mux_en, src_sel_i}),
    .q_o   (ctl_s)
  );

  assign sel_s  = ctl_s[1:0];
  assign en_s   = ctl_s[2 +: NSRC];
  assign done_s = ctl_s[SW-1];

  assign target   = decode_sel(sel_s);
  assign to_pri   = (target == SRC_PRI);
  // after leaving, the primary stays off until the timer is seen cleared
  assign prim_req = to_pri & ~off_wait_q;
  assign prim_act = en_s[SRC_PRI];
  assign prim_ok  = prim_req & done_s;

  always_ff @(posedge int_fast_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q    <= SRC_INT;
      off_wait_q <= 1'b0;
    end else begin
      off_wait_q <= to_pri ? (off_wait_q & done_s) : 1'b1;
      if (!to_pri)     grant_q <= target;
      else if (prim_ok) grant_q <= SRC_PRI;
    end
  end

  // primary kept on until the mux has let go of it
  assign prim_en_o   = prim_req | prim_act;
  assign pll_en_o    = prim_en_o & pll_use_i;
  assign osc_ready_o = prim_ok & prim_act & (grant_q == SRC_PRI);

  assign mux_req = NSRC'(1) << grant_q;
  assign src_clk = {int_clk, sec_clk_i, prim_path_clk};

  rcs_glitch_free_mux #(.N(NSRC)) u_mux (
    .clk_i (src_clk),
    .rst_ni(rst_ni),
    .req_i (mux_req),
    .en_o  (mux_en),
    .clk_o (out_clk)
  );

  assign cpu_clk_o    = out_clk;
  assign periph_clk_o = out_clk;
endmodule

// File: rtl/run_clk_switch_chk.sv
`timescale 1ns/1ps
module run_clk_switch_chk #(
  parameter int unsigned NS = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    sel_i,
  input logic          prim_en_i,
  input logic          pll_en_i,
  input logic          ready_i,
  input logic [NS-1:0] mux_en_i
);
  assert_ready_needs_prim_R5: assert property (
    @(posedge clk_i) disable iff (!rst_ni) ready_i |-> prim_en_i);

  assert_pll_under_prim_R4: assert property (
    @(posedge clk_i) disable iff (!rst_ni) pll_en_i |-> prim_en_i);

  assert_internal_clears_ready_R2: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
      (sel_i[1] && $past(sel_i[1]) && $past(sel_i[1], 2)) |-> !ready_i);

  assert_single_source_R7: assert property (
    @(posedge clk_i) disable iff (!rst_ni) $onehot0(mux_en_i));
endmodule

bind run_clk_switch run_clk_switch_chk #(.NS(rcs_pkg::NSRC)) u_chk (
  .clk_i    (int_fast_clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (src_sel_i),
  .prim_en_i(prim_en_o),
  .pll_en_i (pll_en_o),
  .ready_i  (osc_ready_o),
  .mux_en_i (mux_en)
);

// File: tb/run_clk_switch_test.sv
`timescale 1ns/1ps
module run_clk_switch_test;
  localparam int unsigned OST  = 1024;
  localparam int unsigned LOCK = 200;

  logic       rst_ni = 1'b1;
  logic       fast_clk = 1'b0, slow_clk = 1'b0, prim_clk = 1'b0, pll_clk = 1'b0, sec_clk = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [2:0] ifreq = 3'b111;
  logic       pll_use = 1'b0;
  logic       cpu_clk, periph_clk, prim_en, pll_en, ready;

  int  checks = 0;
  int  fails  = 0;
  bit  mon_on = 1'b0;
  real last_edge = 0.0;

  always #4   fast_clk = ~fast_clk;   // 125 MHz
  always #100 slow_clk = ~slow_clk;
  always #5   prim_clk = ~prim_clk;
  always #3   pll_clk  = ~pll_clk;
  always #15  sec_clk  = ~sec_clk;

  run_clk_switch #(.OST_CYCLES(OST), .LOCK_CYCLES(LOCK), .IFREQ_W(3)) uut (
    .rst_ni(rst_ni), .int_fast_clk_i(fast_clk), .int_slow_clk_i(slow_clk),
    .prim_clk_i(prim_clk), .pll_clk_i(pll_clk), .sec_clk_i(sec_clk),
    .src_sel_i(sel), .int_freq_i(ifreq), .pll_use_i(pll_use),
    .cpu_clk_o(cpu_clk), .periph_clk_o(periph_clk), .prim_en_o(prim_en),
    .pll_en_o(pll_en), .osc_ready_o(ready)
  );

  task automatic chk(input bit ok, input string req, input string what, input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0.2f expected=%0.2f", req, what, act, exp);
    end
  endtask

  // R7: runt pulse monitor on the output clock
  always @(cpu_clk) begin
    if (mon_on && ($realtime - last_edge) < 2.9) begin
      checks++; fails++;
      $display("FAIL R7 runt pulse actual=%0.2f expected>=3.00", $realtime - last_edge);
    end
    last_edge = $realtime;
  end

  function automatic real int_per(input logic [2:0] f);
    if (f == 3'd0) return 200.0;
    return 8.0 * real'(1 << (7 - int'(f)));
  endfunction

  function automatic real exp_per(input logic [1:0] s, input logic [2:0] f, input logic p);
    if (s[1]) return int_per(f);
    if (s[0]) return 30.0;
    return p ? 6.0 : 10.0;
  endfunction

  task automatic meas(output real p);
    real t0;
    @(posedge cpu_clk);
    @(posedge cpu_clk);
    t0 = $realtime;
    @(posedge cpu_clk);
    p = $realtime - t0;
  endtask

  task automatic chk_period(input string req, input real exp);
    real p;
    meas(p);
    chk(p > exp - 0.5 && p < exp + 0.5, req, "cpu period", p, exp);
  endtask

  task automatic chk_state(input string req, input logic [1:0] s, input logic [2:0] f, input logic p);
    bit on_pri;
    on_pri = (s == 2'b00);
    chk_period(req, exp_per(s, f, p));
    @(negedge fast_clk);
    chk(periph_clk == cpu_clk, "R9", "periph vs cpu", real'(periph_clk), real'(cpu_clk));
    chk(ready == on_pri, "R5", "osc_ready", real'(ready), real'(on_pri));
    chk(prim_en == on_pri, "R2", "prim_en", real'(prim_en), real'(on_pri));
    chk(pll_en == (on_pri && p), "R4", "pll_en", real'(pll_en), real'(on_pri && p));
  endtask

  task automatic wait_until(input real t);
    if (t > $realtime) #(t - $realtime);
    @(negedge fast_clk);
  endtask

  task automatic set_freq(input logic [2:0] f);
    mon_on = 1'b0;
    @(negedge fast_clk);
    ifreq = f;
    #500;
    mon_on = 1'b1;
  endtask

  task automatic set_sel(input logic [1:0] s);
    @(negedge fast_clk);
    sel = s;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    real t;
    logic [1:0] cur_sel;
    logic [2:0] cur_f;
    logic       cur_pll;
    void'($urandom(32'h5eed_c1c5));

    #1 rst_ni = 1'b0;
    #50 rst_ni = 1'b1;
    t = $realtime;
    #100;
    @(negedge fast_clk);
    chk(ready == 1'b0, "R10", "ready after reset", real'(ready), 0.0);
    chk(prim_en == 1'b1, "R10", "prim_en after reset", real'(prim_en), 1.0);
    chk(pll_en == 1'b0, "R10", "pll_en after reset", real'(pll_en), 0.0);
    mon_on = 1'b1;
    chk_period("R10", 8.0);                     // internal path during first start-up
    wait_until(t + 10200.0);
    chk(ready == 1'b0, "R3", "ready before start-up count", real'(ready), 0.0);
    wait_until(t + 10900.0);
    chk_state("R3", 2'b00, 3'b111, 1'b0);

    // R2: to the internal block
    set_sel(2'b10);
    #1000;
    chk_state("R2", 2'b10, 3'b111, 1'b0);
    // R1: lower select bit ignored
    set_sel(2'b11);
    #1000;
    chk_state("R1", 2'b11, 3'b111, 1'b0);

    // R8: frequency codes, immediate
    set_freq(3'b101);
    chk_state("R8", 2'b11, 3'b101, 1'b0);
    set_freq(3'b000);
    chk_state("R8", 2'b11, 3'b000, 1'b0);
    set_freq(3'b001);
    chk_state("R8", 2'b11, 3'b001, 1'b0);
    set_freq(3'b110);
    chk_state("R8", 2'b11, 3'b110, 1'b0);
    set_freq(3'b111);

    // R1: secondary
    set_sel(2'b01);
    #1000;
    chk_state("R1", 2'b01, 3'b111, 1'b0);

    // R4/R6: back to primary through the PLL
    pll_use = 1'b1;
    set_sel(2'b00);
    t = $realtime;
    wait_until(t + 300.0);
    chk(prim_en == 1'b1, "R4", "prim_en during wait", real'(prim_en), 1.0);
    chk(pll_en == 1'b1, "R4", "pll_en during wait", real'(pll_en), 1.0);
    wait_until(t + 2000.0);
    chk_period("R6", 30.0);
    wait_until(t + 12200.0);
    chk(ready == 1'b0, "R4", "ready before lock end", real'(ready), 0.0);
    wait_until(t + 12900.0);
    chk_state("R4", 2'b00, 3'b111, 1'b1);

    // R3/R6: short bounce away restarts the full count
    set_sel(2'b10);
    #40;
    set_sel(2'b00);
    t = $realtime;
    wait_until(t + 5000.0);
    chk(ready == 1'b0, "R3", "ready after bounce", real'(ready), 0.0);
    chk_period("R6", 8.0);
    wait_until(t + 13500.0);
    chk_state("R3", 2'b00, 3'b111, 1'b1);

    // random sequence
    cur_sel = 2'b00; cur_f = 3'b111; cur_pll = 1'b1;
    for (int i = 0; i < 12; i++) begin
      logic [1:0] ns;
      logic [2:0] nf;
      ns = 2'($urandom % 4);
      nf = 3'($urandom % 8);
      set_freq(nf);
      cur_f = nf;
      if (ns == 2'b00 && cur_sel != 2'b00) begin
        cur_pll = 1'($urandom % 2);
        pll_use = cur_pll;
      end
      set_sel(ns);
      if (ns == 2'b00 && cur_sel != 2'b00) #13500;
      else #1500;
      cur_sel = ns;
      chk_state(ns == 2'b00 ? "R3" : "R1", cur_sel, cur_f, cur_pll);
    end

    chk(1'b1, "R7", "runt monitor", 0.0, 0.0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule